// File: doc/BRIEF.md
# Address-Banked Two-Port RAM

This block is a simple dual-port memory with one write port and one read port. The storage is split on the address, not on the data width, into two banks of half the depth each. The top address bit picks the bank. A write reaches only the bank it names. A read clocks only the named bank. The other bank loads zeros into its output register, and the two bank outputs are combined with a plain OR. Because only one bank toggles per access, the unused half of the array stays quiet. Because the idle bank is held at zero, the OR needs no select signal after the output registers.

Writes and read requests arrive as valid/ready streams, and read data leaves as a valid/ready stream. The write port never stalls: `wr_ready` is tied high. A read request is accepted when `rd_valid` and `rd_ready` are both high. Its data appears one cycle later with `rsp_valid` set. `rd_ready` is low only while a response is waiting and the consumer holds `rsp_ready` low. During such a stall the response is held unchanged.

Top module: `abk_ram`

## Requirements
- R1: After reset, `rsp_valid` is 0, `rsp_data` is all zeros and `rd_ready` is 1.
- R2: `wr_ready` is always 1. A cycle with `wr_valid` high stores `wr_data` at `wr_addr`, and a later read of that address returns it.
- R3: A write changes only the bank selected by bit ADDR_W-1 of `wr_addr` (0 = low bank, 1 = high bank). The entry with the same lower address bits in the other bank keeps its value, including when a read of that other bank happens in the same cycle.
- R4: A read accepted at a clock edge gives `rsp_valid` = 1 after that edge, with `rsp_data` equal to the stored word at `rd_addr`.
- R5: `rd_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is 1 and `rsp_ready` is 0, both `rsp_valid` and `rsp_data` stay unchanged. A response is dropped (`rsp_valid` goes to 0) after a cycle with `rsp_ready` high and no new read accepted.
- R6: When a write and an accepted read target the same address in the same cycle, the response carries the word held before the write (read-first). The new word is returned by the next read.
- R7: On every accepted read, the bank that is not selected loads zero into its output register. `rsp_data` therefore equals the selected bank's word, whatever the other bank holds (for example all ones).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request ready (always 1) |
| wr_addr | input | ADDR_W | Write address; top bit selects the bank |
| wr_data | input | DATA_W | Write data |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request ready |
| rd_addr | input | ADDR_W | Read address; top bit selects the bank |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response accepted by the consumer |
| rsp_data | output | DATA_W | Read response data, the OR of both bank outputs |

## Verification
Two functions can fall in the same cycle: a write and an accepted read. The bench provokes this with both pointing at the same address, which must return the old word. It also points them at opposite banks with equal lower address bits, which must leave the read bank's word untouched. A stalled response can also meet a new read request. The bench holds `rsp_ready` low while `rd_valid` stays high, then releases it in the cycle where the next read is taken. A behavioural model of the array and of the response slot predicts `rd_ready`, `rsp_valid` and `rsp_data` on every clock, and the outputs are compared against it each cycle.

// File: rtl/abk_pkg.sv
package abk_pkg;

  localparam int unsigned ABK_BANKS = 2;

  typedef enum logic {
    BANK_LO = 1'b0,
    BANK_HI = 1'b1
  } bank_e;

  function automatic bank_e bank_of(input logic msb);
    return msb ? BANK_HI : BANK_LO;
  endfunction

endpackage

// File: rtl/abk_bank_decode.sv
module abk_bank_decode
  import abk_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  localparam int unsigned IDX_W = ADDR_W - 1
) (
  input  logic                 req,
  input  logic [ADDR_W-1:0]    addr,
  output logic [ABK_BANKS-1:0] bank_en,
  output logic [IDX_W-1:0]     idx
);

  bank_e sel;

  assign sel             = bank_of(addr[ADDR_W-1]);
  assign idx             = addr[IDX_W-1:0];
  assign bank_en[BANK_LO] = req && (sel == BANK_LO);
  assign bank_en[BANK_HI] = req && (sel == BANK_HI);

endmodule

// File: rtl/abk_bank.sv
module abk_bank #(
  parameter int unsigned DATA_W     = 12,
  parameter int unsigned BANK_DEPTH = 64,
  localparam int unsigned IDX_W     = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rd_clr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] store [BANK_DEPTH];

  // storage: no reset, written only when this bank is enabled
  always_ff @(posedge clk) begin
    if (wr_en) begin
      store[wr_idx] <= wr_data;
    end
  end

  // output register: loads the word when enabled, zero when another bank reads
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (rd_en) begin
      q <= store[rd_idx];
    end else if (rd_clr) begin
      q <= '0;
    end
  end

  // R7
  rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && rd_clr));

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> (q == '0));

endmodule

// File: rtl/abk_or_merge.sv
module abk_or_merge #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned LANES  = 2
) (
  input  logic [LANES-1:0][DATA_W-1:0] lanes,
  output logic [DATA_W-1:0]            merged
);

  always_comb begin
    merged = '0;
    for (int i = 0; i < LANES; i++) begin
      merged = merged | lanes[i];
    end
  end

endmodule

// File: rtl/abk_ram.sv
module abk_ram
  import abk_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned DEPTH  = 128,
  localparam int unsigned ADDR_W     = $clog2(DEPTH),
  localparam int unsigned BANK_DEPTH = DEPTH / 2,
  localparam int unsigned IDX_W      = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data
);

  if ((DEPTH % 2) != 0 || DEPTH < 4 || (1 << ADDR_W) != DEPTH) begin : g_bad_depth
    $error("abk_ram: DEPTH must be an even power of two of at least 4");
  end

  logic                              rd_fire;
  logic [ABK_BANKS-1:0]              wr_bank_en;
  logic [ABK_BANKS-1:0]              rd_bank_en;
  logic [IDX_W-1:0]                  wr_idx;
  logic [IDX_W-1:0]                  rd_idx;
  logic [ABK_BANKS-1:0][DATA_W-1:0]  bank_q;

  assign wr_ready = 1'b1;
  assign rd_ready = !rsp_valid || rsp_ready;
  assign rd_fire  = rd_valid && rd_ready;

  abk_bank_decode #(.ADDR_W(ADDR_W)) u_wr_dec (
    .req     (wr_valid),
    .addr    (wr_addr),
    .bank_en (wr_bank_en),
    .idx     (wr_idx)
  );

  abk_bank_decode #(.ADDR_W(ADDR_W)) u_rd_dec (
    .req     (rd_fire),
    .addr    (rd_addr),
    .bank_en (rd_bank_en),
    .idx     (rd_idx)
  );

  for (genvar b = 0; b < ABK_BANKS; b++) begin : g_bank
    abk_bank #(.DATA_W(DATA_W), .BANK_DEPTH(BANK_DEPTH)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_bank_en[b]),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_en   (rd_bank_en[b]),
      .rd_clr  (rd_fire && !rd_bank_en[b]),
      .rd_idx  (rd_idx),
      .q       (bank_q[b])
    );
  end

  abk_or_merge #(.DATA_W(DATA_W), .LANES(ABK_BANKS)) u_merge (
    .lanes  (bank_q),
    .merged (rsp_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R3
  wr_one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $onehot(wr_bank_en));

  // R7
  rd_one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_bank_en));

  // R4
  rsp_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rsp_valid);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R7
  one_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((bank_q[0] == '0) || (bank_q[1] == '0)));

endmodule

// File: tb/abk_ram_tb.sv
`timescale 1ns/1ps
module abk_ram_tb;

  localparam int DW    = 12;
  localparam int DEPTH = 128;
  localparam int AW    = $clog2(DEPTH);
  localparam int HALF  = DEPTH / 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_valid, rd_valid, rsp_ready;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data;
  logic          wr_ready, rd_ready, rsp_valid;
  logic [DW-1:0] rsp_data;

  always #2.5 clk = ~clk;

  abk_ram #(.DATA_W(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // reference model
  int model [DEPTH];
  bit exp_valid = 0;
  int exp_data  = 0;

  task automatic chk(input string tag, input bit ok, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: drive at the falling edge, predict, compare after the next falling edge
  task automatic cyc(input bit wv, input int wa, input int wd,
                     input bit rv, input int ra, input bit rr, input string tag);
    bit exp_rdy, fire, nv;
    int nd;
    wr_valid = wv; wr_addr = AW'(wa); wr_data = DW'(wd);
    rd_valid = rv; rd_addr = AW'(ra); rsp_ready = rr;
    #1;
    exp_rdy = !exp_valid || rr;
    chk("R5 rd_ready", rd_ready == exp_rdy, int'(rd_ready), int'(exp_rdy));
    chk("R2 wr_ready", wr_ready == 1'b1, int'(wr_ready), 1);
    fire = rv && exp_rdy;
    nv = exp_valid;
    nd = exp_data;
    if (fire) begin
      nv = 1;
      nd = model[ra];          // read-first: old contents
    end else if (rr) begin
      nv = 0;
    end
    if (wv) model[wa] = wd & ((1 << DW) - 1);
    @(posedge clk);
    @(negedge clk);
    exp_valid = nv;
    exp_data  = nd;
    chk({tag, " rsp_valid"}, rsp_valid == exp_valid, int'(rsp_valid), int'(exp_valid));
    if (exp_valid)
      chk({tag, " rsp_data"}, int'(rsp_data) == exp_data, int'(rsp_data), exp_data);
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, 0, 1, tag);
  endtask

  task automatic rd(input int a, input string tag);
    cyc(0, 0, 0, 1, a, 1, tag);
  endtask

  initial begin
    rst_n = 0; wr_valid = 0; rd_valid = 0; rsp_ready = 1;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", rsp_valid == 1'b0, int'(rsp_valid), 0);
    chk("R1 rsp_data", rsp_data == '0, int'(rsp_data), 0);
    chk("R1 rd_ready", rd_ready == 1'b1, int'(rd_ready), 1);
    rst_n = 1;
    @(negedge clk);

    // R2: fill; the high bank holds all ones, the low bank a pattern
    for (int i = 0; i < DEPTH; i++) begin
      cyc(1, i, (i < HALF) ? ((i * 37 + 5) & 12'h7ff) : 12'hfff, 0, 0, 1, "R2");
    end

    // R4 / R7: reads of both banks, boundary addresses included
    rd(0, "R7");
    rd(HALF - 1, "R7");
    rd(HALF, "R4");
    rd(DEPTH - 1, "R4");
    rd(5, "R7");
    idle("R5");

    // R3: write high bank index 9, low bank index 9 unchanged
    cyc(1, HALF + 9, 12'h0a5, 0, 0, 1, "R3");
    rd(9, "R3");
    rd(HALF + 9, "R3");
    // R3: write low bank while reading the high bank at the same index
    cyc(1, 12, 12'h3c3, 1, HALF + 12, 1, "R3");
    rd(12, "R3");
    rd(HALF + 12, "R3");

    // R6: collision on the same address
    cyc(1, 20, 12'h5a5, 1, 20, 1, "R6");
    rd(20, "R6");
    cyc(1, HALF + 3, 12'h111, 1, HALF + 3, 1, "R6");
    rd(HALF + 3, "R6");

    // R5: stall with a pending request, then release
    cyc(0, 0, 0, 1, 30, 0, "R5");
    cyc(0, 0, 0, 1, HALF + 30, 0, "R5");
    cyc(1, 31, 12'h777, 1, HALF + 30, 0, "R5");
    cyc(0, 0, 0, 1, HALF + 30, 0, "R5");
    cyc(0, 0, 0, 1, HALF + 30, 1, "R5");
    cyc(0, 0, 0, 0, 0, 0, "R5");
    idle("R5");
    idle("R5");
    rd(31, "R2");

    // back-to-back alternating banks
    for (int k = 0; k < 8; k++) begin
      rd((k % 2 == 0) ? k : HALF + k, "R7");
    end
    idle("R4");

    done = 1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule